// File: doc/BRIEF.md
# Fan Stall Monitor

This block watches the pulse output of a cooling-fan tachometer and decides one thing: whether the fan is turning slower than once per measurement window. The default window is one second, which makes the threshold 1 Hz. The block does not estimate speed. It reports the slow condition through an 8-bit control/status register and raises an interrupt request when software has enabled it. The request is meant to be routed to interrupt line 7 of the system interrupt controller, which is outside this block.

The tachometer input is asynchronous. It passes through a two-flop synchroniser, and only its rising edges count as fan activity. A cycle counter measures the time since the last recognised edge. When that count reaches the window length, the slow flag sets. The next recognised edge clears the flag and restarts the window. The window length is a parameter, so a bench can use a short period. Register access uses plain single-cycle control pins: a write strobe with data, and a read port that always shows the current register image. There is no data stream and so no valid/ready handshake.

Register layout: bit 7 is the slow flag (read-only), bit 0 is the interrupt enable (read/write), and bits 6 to 1 are reserved.

Top module: `fan_stall_monitor`

## Requirements
- R1: The tachometer input is synchronised by two flops. Only a low-to-high transition counts as activity, and it is recognised in the third clock edge after the input rises. Falling edges and a level held high do not restart the window.
- R2: While reset is asserted and right after it, the register reads 0x00 and `fan_irq_o` is 0.
- R3: The slow flag (register bit 7) becomes 1 at the WINDOW_CYCLES-th clock edge since reset or since the last recognised edge, counting only edges on which no rising edge was recognised. It reads 0 one clock edge earlier.
- R4: After a recognised rising edge, the slow flag reads 0 from the next clock edge on, and the window count starts again from zero.
- R5: Bit 0 of a write (`reg_wr_en` high) is stored as the interrupt enable and read back on bit 0. Without a write, the enable holds its value.
- R6: Bit 7 is read-only: a written value has no effect on it.
- R7: Bits 6 to 1 always read 0, whatever value is written to them.
- R8: `fan_irq_o` is 1 exactly when the slow flag and the interrupt enable are both 1. It follows either of them within the same cycle.
- R9: Rising edges that keep arriving with a period shorter than the window keep the slow flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_i | input | 1 | Fan tachometer pulse, asynchronous |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wr_data | input | 8 | Register write data; only bit 0 is stored |
| reg_rd_data | output | 8 | Current register image: {slow, 6'b0, enable} |
| fan_irq_o | output | 1 | Fan interrupt request, level, for interrupt line 7 |

## Verification
The bench drives the monitor with several tachometer patterns:
- A silent input shows exactly where in time the window expires.
- A single short pulse after a stall shows how late a recovery is recognised.
- A pulse train faster than the window must never raise the flag.
- A long high level followed by a fall shows that only rising transitions count as activity.

Register writes that set every bit, including the read-only and reserved ones, separate the stored enable from the protected bits. Toggling the enable while the fan is slow or fast shows the interrupt gating.

// File: rtl/fan_mon_pkg.sv
package fan_mon_pkg;
  localparam int REG_W    = 8;
  localparam int SLOW_BIT = 7;
  localparam int EN_BIT   = 0;

  function automatic logic [REG_W-1:0] reg_image(input logic slow, input logic en);
    logic [REG_W-1:0] img;
    img           = '0;
    img[SLOW_BIT] = slow;
    img[EN_BIT]   = en;
    return img;
  endfunction
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_i,
  output logic rise_o
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= tach_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~hist_q;

  // R1: a recognised edge comes from a high input two clocks earlier
  p_edge_from_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $past(tach_i, 2))
    else $error("p_edge_from_input_r1");
endmodule

// File: rtl/stall_window.sv
module stall_window #(
  parameter int unsigned WINDOW_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic slow_o
);
  localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] quiet_q;
  logic             slow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
      slow_q  <= 1'b0;
    end else if (rise_i) begin
      quiet_q <= '0;
      slow_q  <= 1'b0;
    end else if (quiet_q == LAST) begin
      slow_q  <= 1'b1;
    end else begin
      quiet_q <= quiet_q + CNT_W'(1);
    end
  end

  assign slow_o = slow_q;

  // R4: activity clears the flag on the next edge
  p_clear_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> !slow_o)
    else $error("p_clear_on_edge_r4");

  // R3: a full quiet window sets the flag
  p_set_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i && quiet_q == LAST) |=> slow_o)
    else $error("p_set_after_window_r3");
endmodule

// File: rtl/fan_ctl_reg.sv
module fan_ctl_reg
  import fan_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             slow_i,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (wr_en) en_q <= wr_bit;
  end

  assign rd_data = reg_image(slow_i, en_q);
  assign irq_o   = slow_i & en_q;

  // R5: a write stores its bit
  p_enable_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(wr_bit)))
    else $error("p_enable_written_r5");

  // R5: without a write the enable holds
  p_enable_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q))
    else $error("p_enable_holds_r5");
endmodule

// File: rtl/fan_stall_monitor.sv
module fan_stall_monitor
  import fan_mon_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned WINDOW_CYCLES = CLK_HZ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_i,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  output logic             fan_irq_o
);
  logic rise;
  logic slow;
  logic reserved_wr_unused;

  assign reserved_wr_unused = ^{reg_wr_data[REG_W-1:EN_BIT+1]};

  tach_edge_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tach_i (tach_i),
    .rise_o (rise)
  );

  stall_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise),
    .slow_o (slow)
  );

  fan_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_bit  (reg_wr_data[EN_BIT]),
    .slow_i  (slow),
    .rd_data (reg_rd_data),
    .irq_o   (fan_irq_o)
  );

  // R6: a write cannot raise the slow flag on its own
  p_slow_not_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_rd_data[SLOW_BIT] && !rise) |=> !$rose(slow) || $past(u_window.quiet_q == u_window.LAST))
    else $error("p_slow_not_written_r6");
endmodule

// File: tb/test_fan_stall_monitor.sv
module test_fan_stall_monitor;
  localparam int W = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tach_i = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       fan_irq_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R2";

  // reference model state
  bit hist[$];
  int quiet;
  bit m_slow, m_en;

  fan_stall_monitor #(.WINDOW_CYCLES(W)) i_fan_stall_monitor (
    .clk(clk), .rst_n(rst_n), .tach_i(tach_i),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .fan_irq_o(fan_irq_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1'b0, 1'b0, 1'b0};
      quiet = 0; m_slow = 0; m_en = 0;
    end else begin
      bit seen;
      seen = hist[1] && !hist[2];
      hist.push_front(tach_i);
      void'(hist.pop_back());
      if (seen) begin quiet = 0; m_slow = 0; end
      else if (quiet == W - 1) m_slow = 1;
      else quiet++;
      if (reg_wr_en) m_en = reg_wr_data[0];
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (reg_rd_data !== {m_slow, 6'b0, m_en} || fan_irq_o !== (m_slow & m_en)) begin
        fails++;
        $display("FAIL %s model: rd=%h irq=%b expected rd=%h irq=%b", cur_req,
                 reg_rd_data, fan_irq_o, {m_slow, 6'b0, m_en}, m_slow & m_en);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = 8'h00;
  endtask

  task automatic pulse(input int hi, input int lo);
    tach_i = 1'b1; ticks(hi);
    tach_i = 1'b0; ticks(lo);
  endtask

  initial begin
    ticks(3);
    chk("R2", {fan_irq_o, reg_rd_data}, 9'h000);
    rst_n = 1'b1;
    chk("R2", {fan_irq_o, reg_rd_data}, 9'h000);

    cur_req = "R3";
    ticks(W - 1);
    chk("R3", {1'b0, reg_rd_data}, 9'h000);
    ticks(1);
    chk("R3", {1'b0, reg_rd_data}, 9'h080);

    cur_req = "R5";
    wr(8'h01);
    chk("R5", {1'b0, reg_rd_data}, 9'h081);
    chk("R8", {8'h00, fan_irq_o}, 9'h001);

    cur_req = "R4";
    tach_i = 1'b1;
    ticks(2);
    chk("R4", {1'b0, reg_rd_data}, 9'h081);
    ticks(1);
    chk("R4", {1'b0, reg_rd_data}, 9'h001);
    chk("R8", {8'h00, fan_irq_o}, 9'h000);
    tach_i = 1'b0; ticks(2);

    cur_req = "R7";
    wr(8'hFE);
    chk("R7", {1'b0, reg_rd_data}, 9'h000);
    chk("R6", {8'h00, reg_rd_data[7]}, 9'h000);
    wr(8'hFF);
    chk("R7", {1'b0, reg_rd_data}, 9'h001);

    cur_req = "R9";
    for (int i = 0; i < 10; i++) pulse(5, 15);
    chk("R9", {1'b0, reg_rd_data}, 9'h001);

    cur_req = "R1";
    tach_i = 1'b1;
    ticks(W + 5);
    chk("R1", {1'b0, reg_rd_data}, 9'h081);
    tach_i = 1'b0;
    ticks(10);
    chk("R1", {1'b0, reg_rd_data}, 9'h081);

    cur_req = "R6";
    wr(8'h7F);
    chk("R6", {1'b0, reg_rd_data}, 9'h081);
    cur_req = "R8";
    wr(8'h00);
    chk("R8", {fan_irq_o, reg_rd_data}, 9'h080);
    ticks(3);
    chk("R5", {1'b0, reg_rd_data}, 9'h080);

    ticks(2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule